// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block answers on a two-wire serial bus as a target device with a 7-bit address that is set on an input. When a controller addresses it with the write direction, each incoming byte is acknowledged and placed in a one-byte receive register for the local host. When addressed with the read direction, the block shifts out bytes that the host has placed in a one-byte transmit register. Both bus lines are sampled through a synchroniser on the system clock. The block drives a line only by pulling it low, so each line has an output enable and no output value.

When the host falls behind, the block stretches the bus clock instead of losing or inventing data. A byte that completes while the previous one is still unread keeps SCL low until the host reads. A read request that meets an empty transmit register keeps SCL low until the host writes. A synchronous module reset also releases the clock, and it discards whatever was pending.

Top module: `i2cs_top`

## Requirements
- R1: After reset `scl_oe` and `sda_oe` are 0, `rx_full` is 0, `tx_empty` is 1 and `addressed` is 0.
- R2: A START, then an address byte whose upper seven bits equal `own_addr` and whose last bit is 0 (write), is acknowledged by SDA low in the ninth clock, and `addressed` becomes 1. Each following data byte, sent MSB first, is acknowledged and appears on `rx_data` with `rx_full` = 1. A one-cycle `host_rd` pulse clears `rx_full`.
- R3: An address that differs from `own_addr` is not acknowledged (SDA stays high in the ninth clock). `addressed` stays 0, and the data bytes that follow are neither acknowledged nor stored.
- R4: A `host_wr` pulse loads `host_wdata` and clears `tx_empty`. After a matching address with last bit 1 (read), the loaded byte is shifted out MSB first, and `tx_empty` returns to 1 once the byte is taken.
- R5: If a received byte completes while `rx_full` is 1, SCL is held low. The unread byte stays on `rx_data` and the new byte is not acknowledged until the host reads. The new byte is then stored and acknowledged, and SCL is released.
- R6: If a byte is due to be sent and the transmit register is empty, SCL is held low until the host writes. The written byte is then sent.
- R7: In read direction, a NACK (SDA high) from the controller after a byte ends the transfer. `addressed` falls to 0 and the block ignores the bus until the next START.
- R8: SDA rising while SCL is high (STOP) returns the block to idle with `addressed` = 0.
- R9: SDA falling while SCL is high (START) restarts address reception at any point, including as a repeated START in the middle of a transfer, and the direction bit of the new address then applies.
- R10: A one-cycle `mod_rst` pulse releases a stretched SCL, drops the pending receive byte and transmit byte (`rx_full` = 0, `tx_empty` = 1) and clears `addressed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mod_rst | input | 1 | Synchronous module reset: releases the bus and drops pending data |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | 1 pulls the bus clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| own_addr | input | 7 | Address this target answers to |
| host_rd | input | 1 | Host read strobe for the receive register |
| host_wr | input | 1 | Host write strobe for the transmit register |
| host_wdata | input | 8 | Byte written with `host_wr` |
| rx_data | output | 8 | Receive register |
| rx_full | output | 1 | Receive register holds an unread byte |
| tx_empty | output | 1 | Transmit register holds no byte |
| addressed | output | 1 | Currently selected as target |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except when it makes a START or a STOP. They also assume that it never makes a START or a STOP while the target is driving SDA, and that it holds each SCL level for many system clocks. The bench's bus model keeps within these limits. It waits a fixed number of system cycles between line changes and waits for SCL to read high before it counts a high phase, so a stretched clock simply lengthens the bit. `mod_rst` is pulsed only while SCL is held low by the stall.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RXSTALL,
    ST_RACK,
    ST_TXWAIT,
    ST_TX,
    ST_TACK
  } eng_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_V}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_hold.sv
module i2cs_hold
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_pop,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_full
);
  logic rx_full_n, tx_full_n;

  always_comb begin
    rx_full_n = rx_full;
    tx_full_n = tx_full;
    if (flush) begin
      rx_full_n = 1'b0;
      tx_full_n = 1'b0;
    end else begin
      if (rx_push)      rx_full_n = 1'b1;
      else if (host_rd) rx_full_n = 1'b0;
      if (host_wr)      tx_full_n = 1'b1;
      else if (tx_pop)  tx_full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      tx_full <= 1'b0;
    end else begin
      rx_full <= rx_full_n;
      tx_full <= tx_full_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push) rx_data <= rx_byte;
    if (host_wr) tx_data <= host_wdata;
  end

  AST_RX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full) else $error("rx overwrite"); // R5
  AST_TX_POP_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_full) else $error("tx underflow send"); // R6
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rx_full,
  input  logic              tx_full,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_pop,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              addressed
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  eng_state_t        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              rw, rw_n, mack, mack_n;
  logic              sda_oe_n, scl_oe_n, addr_n;

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    sh_n     = sh;
    rw_n     = rw;
    mack_n   = mack;
    sda_oe_n = sda_oe;
    scl_oe_n = scl_oe;
    addr_n   = addressed;
    rx_push  = 1'b0;
    tx_pop   = 1'b0;
    if (flush) begin
      st_n = ST_IDLE; sda_oe_n = 1'b0; scl_oe_n = 1'b0; addr_n = 1'b0;
    end else if (start_det) begin
      st_n = ST_ADDR; cnt_n = '0; sda_oe_n = 1'b0; scl_oe_n = 1'b0; addr_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; sda_oe_n = 1'b0; scl_oe_n = 1'b0; addr_n = 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt != FULL_CNT) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL_CNT) begin
            if (st == ST_ADDR) begin
              if (sh[BYTE_W-1:1] == own_addr) begin
                sda_oe_n = 1'b1; rw_n = sh[0]; addr_n = 1'b1; st_n = ST_AACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (!rx_full) begin
              rx_push = 1'b1; sda_oe_n = 1'b1; st_n = ST_RACK;
            end else begin
              scl_oe_n = 1'b1; st_n = ST_RXSTALL;
            end
          end
        end
        ST_RXSTALL: begin
          if (!rx_full) begin
            rx_push = 1'b1; sda_oe_n = 1'b1; scl_oe_n = 1'b0; st_n = ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            sda_oe_n = 1'b0; cnt_n = '0; st_n = ST_RX;
          end
        end
        ST_AACK, ST_TACK: begin
          if (st == ST_TACK && scl_rise) mack_n = sda_s;
          if (scl_fall) begin
            sda_oe_n = 1'b0;
            cnt_n    = '0;
            if (st == ST_AACK && !rw) begin
              st_n = ST_RX;
            end else if (st == ST_TACK && mack) begin
              st_n = ST_IDLE; addr_n = 1'b0;
            end else if (tx_full) begin
              tx_pop = 1'b1; sh_n = tx_data; sda_oe_n = ~tx_data[BYTE_W-1]; st_n = ST_TX;
            end else begin
              scl_oe_n = 1'b1; st_n = ST_TXWAIT;
            end
          end
        end
        ST_TXWAIT: begin
          if (tx_full) begin
            tx_pop = 1'b1; sh_n = tx_data; sda_oe_n = ~tx_data[BYTE_W-1];
            scl_oe_n = 1'b0; cnt_n = '0; st_n = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST_TX) begin
              sda_oe_n = 1'b0; st_n = ST_TACK;
            end else begin
              sh_n     = {sh[BYTE_W-2:0], 1'b0};
              sda_oe_n = ~sh[BYTE_W-2];
              cnt_n    = cnt + 1'b1;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rw        <= 1'b0;
      mack      <= 1'b1;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      addressed <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      sh        <= sh_n;
      rw        <= rw_n;
      mack      <= mack_n;
      sda_oe    <= sda_oe_n;
      scl_oe    <= scl_oe_n;
      addressed <= addr_n;
    end
  end

  assign rx_byte = sh;

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(flush)) |-> !scl_s) else $error("sda moved with scl high"); // R2
  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> $past(sh[BYTE_W-1:1] == own_addr)) else $error("ack without match"); // R3
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              addressed
);
  logic [1:0]        bus_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              rx_push, tx_pop, tx_full;
  logic [BYTE_W-1:0] rx_byte, tx_data;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

  i2cs_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2cs_hold u_hold (
    .clk(clk), .rst_n(rst_n), .flush(mod_rst),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_full(rx_full), .tx_data(tx_data), .tx_full(tx_full));

  i2cs_engine u_eng (
    .clk(clk), .rst_n(rst_n), .flush(mod_rst),
    .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .rx_full(rx_full), .tx_full(tx_full), .tx_data(tx_data),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .addressed(addressed));

  assign tx_empty = ~tx_full;

  AST_STRETCH_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> ($past(host_rd, 2) || $past(host_wr, 2) || $past(mod_rst)))
    else $error("scl released without service"); // R10
endmodule

// File: tb/tb_i2cs_top.sv
module tb_i2cs_top;
  logic       clk, rst_n, mod_rst;
  logic       scl_m_low, sda_m_low;
  logic       scl_oe, sda_oe;
  logic [6:0] own_addr;
  logic       host_rd, host_wr;
  logic [7:0] host_wdata, rx_data;
  logic       rx_full, tx_empty, addressed;
  logic       scl_line, sda_line;
  logic       rd_en;
  int         checks, errors;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  localparam int T = 15;

  assign scl_line = !(scl_m_low || scl_oe);
  assign sda_line = !(sda_m_low || sda_oe);

  i2cs_top dut (
    .clk(clk), .rst_n(rst_n), .mod_rst(mod_rst),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .own_addr(own_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .rx_data(rx_data), .rx_full(rx_full),
    .tx_empty(tx_empty), .addressed(addressed));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  // monitor: host reads the receive register and compares with the scoreboard
  initial begin
    host_rd = 1'b0;
    forever begin
      @(negedge clk);
      host_rd = 1'b0;
      if (rd_en && rx_full && rst_n) begin
        checks++;
        if (rxq.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected byte actual=%0h expected=none", rx_data);
        end else begin
          logic [7:0] e;
          e = rxq.pop_front();
          if (rx_data != e) begin
            errors++;
            $display("FAIL R2 rx_data actual=%0h expected=%0h", rx_data, e);
          end
        end
        host_rd = 1'b1;
      end
    end
  end

  task automatic host_write(input logic [7:0] b, input bit push);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
    if (push) txq.push_back(b);
  endtask

  task automatic m_start();
    sda_m_low = 1'b1; wait_cyc(T); scl_m_low = 1'b1; wait_cyc(T);
  endtask

  task automatic m_rstart();
    sda_m_low = 1'b0; wait_cyc(T); scl_m_low = 1'b0; wait_scl_high(); wait_cyc(T);
    sda_m_low = 1'b1; wait_cyc(T); scl_m_low = 1'b1; wait_cyc(T);
  endtask

  task automatic m_stop();
    sda_m_low = 1'b1; wait_cyc(T); scl_m_low = 1'b0; wait_scl_high(); wait_cyc(T);
    sda_m_low = 1'b0; wait_cyc(T);
  endtask

  task automatic wbit(input logic b);
    sda_m_low = ~b; wait_cyc(T); scl_m_low = 1'b0; wait_scl_high(); wait_cyc(T);
    scl_m_low = 1'b1; wait_cyc(T);
  endtask

  task automatic rbit(output logic b);
    sda_m_low = 1'b0; wait_cyc(T); scl_m_low = 1'b0; wait_scl_high(); wait_cyc(T);
    b = sda_line; scl_m_low = 1'b1; wait_cyc(T);
  endtask

  task automatic wbits8(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    wbits8(v); rbit(ack);
  endtask

  task automatic rbyte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(nack);
  endtask

  task automatic rbyte_chk(input string tag, input logic nack);
    logic [7:0] v, e;
    rbyte(v, nack);
    e = (txq.size() != 0) ? txq.pop_front() : 8'h00;
    chk(tag, v, e);
  endtask

  initial begin
    int unsigned wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    checks = 0; errors = 0;
    rst_n = 1'b0; mod_rst = 1'b0; scl_m_low = 1'b0; sda_m_low = 1'b0;
    host_wr = 1'b0; host_wdata = '0; own_addr = 7'h2D; rd_en = 1'b1;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 addressed", addressed, 0);

    // R2 write transfer, R8 stop
    m_start();
    wbyte({7'h2D, 1'b0}, ack);
    chk("R2 addr ack", ack, 0);
    chk("R2 addressed", addressed, 1);
    rxq.push_back(8'hC3); wbyte(8'hC3, ack); chk("R2 data ack 1", ack, 0);
    rxq.push_back(8'h18); wbyte(8'h18, ack); chk("R2 data ack 2", ack, 0);
    m_stop();
    wait_cyc(10);
    chk("R8 addressed after stop", addressed, 0);
    chk("R2 all bytes read", rxq.size(), 0);
    chk("R2 rx_full cleared", rx_full, 0);

    // R3 address mismatch
    m_start();
    wbyte({7'h33, 1'b0}, ack);
    chk("R3 no addr ack", ack, 1);
    chk("R3 addressed", addressed, 0);
    wbyte(8'h5E, ack);
    chk("R3 no data ack", ack, 1);
    chk("R3 rx_full", rx_full, 0);
    m_stop();

    // R4 read, R6 underflow stretch, R7 nack
    host_write(8'hA5, 1);
    wait_cyc(2);
    chk("R4 tx_empty after write", tx_empty, 0);
    m_start();
    wbyte({7'h2D, 1'b1}, ack);
    chk("R4 read addr ack", ack, 0);
    chk("R4 tx_empty after take", tx_empty, 1);
    rbyte_chk("R4 read byte", 1'b0);
    fork
      rbyte_chk("R6 byte after stretch", 1'b1);
      begin
        wait_cyc(40);
        chk("R6 scl held low", scl_line, 0);
        host_write(8'h3C, 1);
      end
    join
    wait_cyc(10);
    chk("R7 addressed after nack", addressed, 0);
    chk("R7 sda released", sda_oe, 0);
    m_stop();

    // R5 receive overrun stretch
    rd_en = 1'b0;
    m_start();
    wbyte({7'h2D, 1'b0}, ack);
    rxq.push_back(8'h21); rxq.push_back(8'h42);
    wbyte(8'h21, ack);
    chk("R5 first ack", ack, 0);
    wbits8(8'h42);
    fork
      rbit(ack);
      begin
        wait_cyc(40);
        chk("R5 scl held low", scl_line, 0);
        chk("R5 old byte kept", rx_data, 8'h21);
        chk("R5 no ack during stall", sda_oe, 0);
        rd_en = 1'b1;
      end
    join
    chk("R5 ack after read", ack, 0);
    wait_cyc(10);
    chk("R5 both bytes read", rxq.size(), 0);
    m_stop();

    // R9 repeated start into read direction
    m_start();
    wbyte({7'h2D, 1'b0}, ack);
    rxq.push_back(8'h11); wbyte(8'h11, ack);
    chk("R9 write ack", ack, 0);
    host_write(8'h77, 1);
    m_rstart();
    wbyte({7'h2D, 1'b1}, ack);
    chk("R9 readdress ack", ack, 0);
    rbyte_chk("R9 read after restart", 1'b1);
    m_stop();
    wait_cyc(10);
    chk("R9 rx drained", rxq.size(), 0);

    // R10 module reset releases a stall
    rd_en = 1'b0;
    host_write(8'h99, 0);
    m_start();
    wbyte({7'h2D, 1'b0}, ack);
    wbyte(8'h55, ack);
    wbits8(8'h66);
    fork
      rbit(ack);
      begin
        wait_cyc(40);
        chk("R10 stalled before reset", scl_line, 0);
        @(negedge clk); mod_rst = 1'b1;
        @(negedge clk); mod_rst = 1'b0;
        wait_cyc(3);
        chk("R10 scl released", scl_oe, 0);
        chk("R10 rx_full", rx_full, 0);
        chk("R10 tx_empty", tx_empty, 1);
        chk("R10 addressed", addressed, 0);
      end
    join
    chk("R10 no ack after reset", ack, 1);
    m_stop();
    rd_en = 1'b1;
    wait_cyc(10);
    chk("R10 nothing delivered", rx_full, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule